// File: doc/BRIEF.md
# Addend-Tuned PTP Time Counter

This block keeps a 64-bit system time for a precision time protocol clock. On every reference clock edge a 32-bit phase accumulator adds a software-programmed addend. Each carry out of the accumulator advances the time counter by one tick, so software trims the rate by rewriting the addend. With the reset addend at a 50 MHz reference, one tick is 32 ns. Software gets nanoseconds from a tick count with a left shift of 5.

Software reaches the block through a simple 32-bit register port made of valid, write and address. Each 64-bit quantity is split into a low word and a high word. A low-word write is only staged, and the following high-word write commits both halves in one cycle. A low-word read of the time freezes the high word for the read that follows. A target comparator raises a pending flag when the time becomes equal to the target. Two external event inputs, slave and master, each capture the current time into their own snapshot pair. The event flags are cleared by writing a one to them. The interrupt output combines the flags with their mask bits, and a soft-reset control bit holds the timebase at zero.

Top module: `ptp_tick_clock`

## Requirements
- R1: After reset, control reads 0, the addend reads 0xA0000000, the target reads 1 (high word 0), and irqOut is low.
- R2: Each clock the accumulator adds the addend modulo 2^32, and a carry out of bit 31 adds one to the time. After N accumulations from zero, the time is floor(N*addend/2^32) and the accumulator is (N*addend) mod 2^32.
- R3: A read of the time low word latches the high word. A later read of the time high word returns that latched value, even if the time has changed in between.
- R4: A write to the time low word is staged and leaves the time unchanged. A write to the time high word loads {high, staged low} into the time in one step.
- R5: Event bit 1 (target pending) sets in the cycle after the time becomes equal to the 64-bit target. The target is written low word first and committed by the high-word write.
- R6: Writing a 1 to an event bit (bits 1 to 3) clears that flag, and writing a 0 leaves it unchanged.
- R7: A rising edge on auxSlaveIn sets event bit 2 and copies the time into the slave snapshot. A level held high does not set the flag again, and the snapshot holds until the next rising edge.
- R8: A rising edge on auxMasterIn sets event bit 3 and copies the time into the master snapshot, leaving the slave snapshot untouched.
- R9: irqOut is high exactly when some event bit n (n = 1, 2, 3) is set together with control bit n. Control bit 4 is stored but gates nothing.
- R10: While control bit 0 is 1, the time and the accumulator are held at zero and all event flags are cleared. The addend keeps its value.
- R11: Byte addresses are as follows. Control 0x00, event 0x04, addend 0x08, accumulator 0x0C (read only), time 0x20/0x24, target 0x28/0x2C, slave snapshot 0x30/0x34, master snapshot 0x38/0x3C, each given as low/high. Read data appears on regRdata one cycle after the read is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regValid | input | 1 | Register access this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 8 | Byte address of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, registered |
| auxSlaveIn | input | 1 | Asynchronous slave event input |
| auxMasterIn | input | 1 | Asynchronous master event input |
| irqOut | output | 1 | Interrupt request |

## Verification
A write takes effect at the clock edge on which it is presented. Read data is registered and is sampled on the falling edge after the read's edge. irqOut is combinational from the registers, so it is checked half a cycle after the write that changes a flag or a mask. An event input passes two synchroniser stages and an edge register before the capture, three edges in all, so the bench waits five cycles before it reads a flag or a snapshot, with the time frozen by a zero addend so the captured value is exact. Rate checks release the soft reset and then zero the addend exactly K+1 edges later. The bench then compares the frozen time and accumulator with floor(N*A/2^32) and N*A mod 2^32, computed in the bench.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int WORD_W = 32;
  localparam int TIME_W = 2 * WORD_W;

  localparam logic [7:0] ADR_CTRL    = 8'h00;
  localparam logic [7:0] ADR_EVT     = 8'h04;
  localparam logic [7:0] ADR_ADDEND  = 8'h08;
  localparam logic [7:0] ADR_ACC     = 8'h0C;
  localparam logic [7:0] ADR_TIME_LO = 8'h20;
  localparam logic [7:0] ADR_TIME_HI = 8'h24;
  localparam logic [7:0] ADR_TGT_LO  = 8'h28;
  localparam logic [7:0] ADR_TGT_HI  = 8'h2C;
  localparam logic [7:0] ADR_SLV_LO  = 8'h30;
  localparam logic [7:0] ADR_SLV_HI  = 8'h34;
  localparam logic [7:0] ADR_MST_LO  = 8'h38;
  localparam logic [7:0] ADR_MST_HI  = 8'h3C;

  // strobes from the register control to the time datapath
  typedef struct packed {
    logic              softRst;
    logic              timeLoWr;
    logic              timeHiWr;
    logic              timeLoRd;
    logic              tgtLoWr;
    logic              tgtHiWr;
    logic [WORD_W-1:0] wdata;
    logic [WORD_W-1:0] addend;
  } ptc_strobe_t;
endpackage

// File: rtl/ptc_datapath.sv
module ptc_datapath
  import ptc_pkg::*;
#(
  parameter int              SYNC_STAGES  = 2,
  parameter int              AUX_N        = 2,
  parameter logic [TIME_W-1:0] TARGET_RESET = 64'd1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ptc_strobe_t                    strb,
  input  logic [AUX_N-1:0]               auxIn,
  output logic [TIME_W-1:0]              timeNow,
  output logic [WORD_W-1:0]              timeHiShadow,
  output logic [TIME_W-1:0]              targetNow,
  output logic [AUX_N-1:0][TIME_W-1:0]   snapTime,
  output logic [WORD_W-1:0]              accNow,
  output logic                           hitPulse,
  output logic [AUX_N-1:0]               auxPulse
);
  logic [WORD_W:0]   accSum;
  logic [WORD_W-1:0] timeStage;
  logic [WORD_W-1:0] tgtStage;
  logic              matchNow;
  logic              matchPrev;

  assign accSum = {1'b0, accNow} + {1'b0, strb.addend};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accNow  <= '0;
      timeNow <= '0;
    end else if (strb.softRst) begin
      accNow  <= '0;
      timeNow <= '0;
    end else begin
      accNow <= accSum[WORD_W-1:0];
      if (strb.timeHiWr)
        timeNow <= {strb.wdata, timeStage};
      else if (accSum[WORD_W])
        timeNow <= timeNow + TIME_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeStage    <= '0;
      tgtStage     <= '0;
      targetNow    <= TARGET_RESET;
      timeHiShadow <= '0;
      matchPrev    <= 1'b1;
    end else begin
      if (strb.timeLoWr) timeStage <= strb.wdata;
      if (strb.tgtLoWr)  tgtStage  <= strb.wdata;
      if (strb.tgtHiWr)  targetNow <= {strb.wdata, tgtStage};
      if (strb.timeLoRd) timeHiShadow <= timeNow[TIME_W-1:WORD_W];
      matchPrev <= matchNow;
    end
  end

  assign matchNow = (timeNow == targetNow);
  assign hitPulse = matchNow & ~matchPrev;

  for (genvar g = 0; g < AUX_N; g++) begin : g_aux
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   lastQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ       <= '0;
        lastQ       <= 1'b0;
        snapTime[g] <= '0;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-2:0], auxIn[g]};
        lastQ <= syncQ[SYNC_STAGES-1];
        if (auxPulse[g]) snapTime[g] <= timeNow;
      end
    end
    assign auxPulse[g] = syncQ[SYNC_STAGES-1] & ~lastQ;

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !auxPulse[g] |=> $stable(snapTime[g])); // R7
  end

  AST_SOFT_RST_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.softRst |=> (timeNow == '0 && accNow == '0)); // R10
  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.softRst && !strb.timeHiWr) |=>
      (timeNow == $past(timeNow) || timeNow == $past(timeNow) + TIME_W'(1))); // R2
  AST_TIME_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.softRst && strb.timeHiWr) |=>
      timeNow == {$past(strb.wdata), $past(timeStage)}); // R4
endmodule

// File: rtl/ptc_ctrl.sv
module ptc_ctrl
  import ptc_pkg::*;
#(
  parameter logic [WORD_W-1:0] ADDEND_RESET = 32'hA000_0000,
  parameter int                AUX_N        = 2,
  localparam int               EVT_W        = AUX_N + 1,
  localparam int               CTRL_W       = EVT_W + 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regValid,
  input  logic                          regWrite,
  input  logic [7:0]                    regAddr,
  input  logic [WORD_W-1:0]             regWdata,
  output logic [WORD_W-1:0]             regRdata,
  input  logic [TIME_W-1:0]             timeNow,
  input  logic [WORD_W-1:0]             timeHiShadow,
  input  logic [TIME_W-1:0]             targetNow,
  input  logic [AUX_N-1:0][TIME_W-1:0]  snapTime,
  input  logic [WORD_W-1:0]             accNow,
  input  logic                          hitPulse,
  input  logic [AUX_N-1:0]              auxPulse,
  output ptc_strobe_t                   strb,
  output logic                          irqOut
);
  logic [CTRL_W-1:0] ctrlReg;   // bit0 soft reset, bits 1..EVT_W masks, top bit stored only
  logic [WORD_W-1:0] addendReg;
  logic [EVT_W:1]    evtReg;
  logic [EVT_W:1]    setVec;
  logic [EVT_W:1]    clrVec;
  logic              wr;
  logic              rd;

  assign wr = regValid & regWrite;
  assign rd = regValid & ~regWrite;

  always_comb begin
    strb          = '0;
    strb.softRst  = ctrlReg[0];
    strb.timeLoWr = wr && regAddr == ADR_TIME_LO;
    strb.timeHiWr = wr && regAddr == ADR_TIME_HI;
    strb.timeLoRd = rd && regAddr == ADR_TIME_LO;
    strb.tgtLoWr  = wr && regAddr == ADR_TGT_LO;
    strb.tgtHiWr  = wr && regAddr == ADR_TGT_HI;
    strb.wdata    = regWdata;
    strb.addend   = addendReg;
  end

  assign setVec = {auxPulse, hitPulse};
  assign clrVec = (wr && regAddr == ADR_EVT) ? regWdata[EVT_W:1] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      addendReg <= ADDEND_RESET;
      evtReg    <= '0;
    end else begin
      if (wr && regAddr == ADR_CTRL)   ctrlReg   <= regWdata[CTRL_W-1:0];
      if (wr && regAddr == ADR_ADDEND) addendReg <= regWdata;
      if (ctrlReg[0]) evtReg <= '0;
      else            evtReg <= (evtReg & ~clrVec) | setVec;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regRdata <= '0;
    else if (rd) begin
      case (regAddr)
        ADR_CTRL:    regRdata <= WORD_W'(ctrlReg);
        ADR_EVT:     regRdata <= WORD_W'({evtReg, 1'b0});
        ADR_ADDEND:  regRdata <= addendReg;
        ADR_ACC:     regRdata <= accNow;
        ADR_TIME_LO: regRdata <= timeNow[WORD_W-1:0];
        ADR_TIME_HI: regRdata <= timeHiShadow;
        ADR_TGT_LO:  regRdata <= targetNow[WORD_W-1:0];
        ADR_TGT_HI:  regRdata <= targetNow[TIME_W-1:WORD_W];
        ADR_SLV_LO:  regRdata <= snapTime[0][WORD_W-1:0];
        ADR_SLV_HI:  regRdata <= snapTime[0][TIME_W-1:WORD_W];
        ADR_MST_LO:  regRdata <= snapTime[AUX_N-1][WORD_W-1:0];
        ADR_MST_HI:  regRdata <= snapTime[AUX_N-1][TIME_W-1:WORD_W];
        default:     regRdata <= '0;
      endcase
    end
  end

  assign irqOut = |(evtReg & ctrlReg[EVT_W:1]);

  AST_HIT_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (hitPulse && !ctrlReg[0]) |=> evtReg[1]); // R5
  AST_W1C_SLAVE: assert property (@(posedge clk) disable iff (!rstN)
    (wr && regAddr == ADR_EVT && regWdata[2] && !auxPulse[0]) |=> !evtReg[2]); // R6
  AST_SOFT_RST_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReg[0] |=> (evtReg == '0)); // R10
endmodule

// File: rtl/ptp_tick_clock.sv
module ptp_tick_clock
  import ptc_pkg::*;
#(
  parameter logic [WORD_W-1:0] ADDEND_RESET = 32'hA000_0000,
  parameter logic [TIME_W-1:0] TARGET_RESET = 64'd1,
  parameter int                SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regValid,
  input  logic        regWrite,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        auxSlaveIn,
  input  logic        auxMasterIn,
  output logic        irqOut
);
  localparam int AUX_N = 2;

  ptc_strobe_t                   strb;
  logic [TIME_W-1:0]             timeNow;
  logic [WORD_W-1:0]             timeHiShadow;
  logic [TIME_W-1:0]             targetNow;
  logic [AUX_N-1:0][TIME_W-1:0]  snapTime;
  logic [WORD_W-1:0]             accNow;
  logic                          hitPulse;
  logic [AUX_N-1:0]              auxPulse;

  ptc_ctrl #(.ADDEND_RESET(ADDEND_RESET), .AUX_N(AUX_N)) i_ctrl (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .timeNow(timeNow), .timeHiShadow(timeHiShadow), .targetNow(targetNow),
    .snapTime(snapTime), .accNow(accNow), .hitPulse(hitPulse),
    .auxPulse(auxPulse), .strb(strb), .irqOut(irqOut)
  );

  ptc_datapath #(.SYNC_STAGES(SYNC_STAGES), .AUX_N(AUX_N),
                 .TARGET_RESET(TARGET_RESET)) i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .auxIn({auxMasterIn, auxSlaveIn}),
    .timeNow(timeNow), .timeHiShadow(timeHiShadow), .targetNow(targetNow),
    .snapTime(snapTime), .accNow(accNow), .hitPulse(hitPulse),
    .auxPulse(auxPulse)
  );
endmodule

// File: tb/test_ptp_tick_clock.sv
module test_ptp_tick_clock;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regValid = 1'b0;
  logic        regWrite = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        auxSlaveIn = 1'b0;
  logic        auxMasterIn = 1'b0;
  logic        irqOut;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  ptp_tick_clock i_ptp_tick_clock (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .auxSlaveIn(auxSlaveIn), .auxMasterIn(auxMasterIn), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // callers sit on a falling edge; each access occupies one clock
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a;
    @(negedge clk);
    regValid = 1'b0;
    d = regRdata;
  endtask

  task automatic rdTime(output logic [63:0] t);
    logic [31:0] lo, hi;
    rd(8'h20, lo);
    rd(8'h24, hi);
    t = {hi, lo};
  endtask

  task automatic setTime(input logic [63:0] t);
    wr(8'h20, t[31:0]);
    wr(8'h24, t[63:32]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] t;
    logic [31:0] addends [6];
    int          kList [4];
    addends = '{32'h8000_0000, 32'hA000_0000, 32'hFFFF_FFFF,
                32'h1234_5678, 32'h4000_0000, 32'h0000_0001};
    kList = '{0, 3, 17, 40};

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    chk("R1 irq", 64'(irqOut), 64'd0);
    rd(8'h00, d); chk("R1 ctrl", 64'(d), 64'd0);
    rd(8'h08, d); chk("R1 addend", 64'(d), 64'hA000_0000);
    rd(8'h28, d); chk("R1 target lo", 64'(d), 64'd1);
    rd(8'h2C, d); chk("R1 target hi", 64'(d), 64'd0);

    // R5 the running time passes the reset target of 1
    repeat (4) @(negedge clk);
    rd(8'h04, d); chk("R5 pending after reset", 64'(d[1]), 64'd1);

    // R2 rate sweep: N = K+1 accumulations between release and freeze
    foreach (addends[i]) begin
      foreach (kList[j]) begin
        logic [63:0] prod;
        wr(8'h00, 32'h1);
        wr(8'h08, addends[i]);
        wr(8'h00, 32'h0);
        repeat (kList[j]) @(negedge clk);
        wr(8'h08, 32'h0);
        prod = 64'(kList[j] + 1) * 64'(addends[i]);
        rdTime(t); chk("R2 time", t, prod >> 32);
        rd(8'h0C, d); chk("R2 accumulator", 64'(d), 64'(prod[31:0]));
      end
    end

    // R4 split write (addend is 0, time frozen)
    setTime(64'h0000_0007_AAAA_0000);
    rdTime(t); chk("R4 commit", t, 64'h0000_0007_AAAA_0000);
    wr(8'h20, 32'h5);
    rdTime(t); chk("R4 low staged only", t, 64'h0000_0007_AAAA_0000);
    wr(8'h24, 32'h9);
    rdTime(t); chk("R4 high commits", t, 64'h0000_0009_0000_0005);

    // R3 coherent high word
    rd(8'h20, d); chk("R3 low", 64'(d), 64'h5);
    setTime(64'h0000_0020_0000_0100);
    rd(8'h24, d); chk("R3 latched high", 64'(d), 64'h9);
    rdTime(t); chk("R3 fresh pair", t, 64'h0000_0020_0000_0100);

    // R5 target reached by counting
    wr(8'h04, 32'hE);
    wr(8'h28, 32'h108);
    wr(8'h2C, 32'h20);
    rd(8'h04, d); chk("R5 not yet pending", 64'(d[1]), 64'd0);
    wr(8'h08, 32'h8000_0000);
    repeat (40) @(negedge clk);
    wr(8'h08, 32'h0);
    rd(8'h04, d); chk("R5 pending", 64'(d[1]), 64'd1);
    rdTime(t); chk("R5 time past target", 64'(t > 64'h20_0000_0108), 64'd1);

    // R6 write-one-to-clear
    wr(8'h04, 32'h0);
    rd(8'h04, d); chk("R6 zero write keeps", 64'(d[1]), 64'd1);

    // R9 interrupt gating (mask bit n enables flag n)
    chk("R9 unmasked off", 64'(irqOut), 64'd0);
    wr(8'h00, 32'h2); chk("R9 target enabled", 64'(irqOut), 64'd1);
    wr(8'h00, 32'h14); chk("R9 other masks", 64'(irqOut), 64'd0);
    wr(8'h00, 32'h2);
    wr(8'h04, 32'h2);
    rd(8'h04, d); chk("R6 one clears", 64'(d[1]), 64'd0);
    chk("R9 cleared flag", 64'(irqOut), 64'd0);

    // R7 slave capture
    setTime(64'h0000_0003_0000_0077);
    auxSlaveIn = 1'b1;
    repeat (5) @(negedge clk);
    rd(8'h04, d); chk("R7 slave flag", 64'(d[3:2]), 64'h1);
    rd(8'h34, d); chk("R7 slave snap hi", 64'(d), 64'h3);
    rd(8'h30, d); chk("R7 slave snap lo", 64'(d), 64'h77);
    setTime(64'h0000_0004_0000_0088);
    wr(8'h04, 32'h4);
    repeat (5) @(negedge clk);
    rd(8'h04, d); chk("R7 held level no retrigger", 64'(d[2]), 64'd0);
    rd(8'h30, d); chk("R7 snapshot holds", 64'(d), 64'h77);
    auxSlaveIn = 1'b0;

    // R8 master capture
    wr(8'h00, 32'h8);
    auxMasterIn = 1'b1;
    repeat (5) @(negedge clk);
    auxMasterIn = 1'b0;
    rd(8'h04, d); chk("R8 master flag", 64'(d[3:2]), 64'h2);
    chk("R9 master enabled", 64'(irqOut), 64'd1);
    rd(8'h3C, d); chk("R8 master snap hi", 64'(d), 64'h4);
    rd(8'h38, d); chk("R8 master snap lo", 64'(d), 64'h88);
    rd(8'h34, d); chk("R8 slave untouched", 64'(d), 64'h3);

    // R10 soft reset
    wr(8'h08, 32'h8000_0000);
    wr(8'h00, 32'h1);
    repeat (6) @(negedge clk);
    rdTime(t); chk("R10 time held", t, 64'd0);
    rd(8'h0C, d); chk("R10 accumulator held", 64'(d), 64'd0);
    rd(8'h04, d); chk("R10 flags cleared", 64'(d), 64'd0);
    rd(8'h08, d); chk("R10 addend kept", 64'(d), 64'h8000_0000);
    chk("R10 irq low", 64'(irqOut), 64'd0);

    // R11 unmapped address reads zero
    rd(8'h10, d); chk("R11 unmapped", 64'(d), 64'd0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule